// File: doc/BRIEF.md
# Acknowledge-Tracking Coalescing Counter

This block follows one periodic interrupt line that fans out to several destination processors. When an interrupt is delivered, the block records which destinations accepted it. It holds a bitmap of the destinations that still owe an acknowledge, along with a count of them. While that count is nonzero, any new assertion of the line is reported as coalesced. The surrounding logic then drops that assertion instead of sending it.

Each destination returns an acknowledge strobe, and the block can take several of them in the same cycle. If a delivery is attempted while acknowledges are still outstanding, the block refuses it and raises an error pulse. A clear input empties the state. After a state reload, a per-destination restore step rebuilds the bitmap one destination at a time from an external "still pending" bit.

In every port bitmap, bit i stands for destination i. All outputs are registered. Each output reflects the inputs that were sampled at the previous rising clock edge.

Top module: `ackt_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs (`pend_cnt`, `pend_map`, `coalesced`, `err_deliver`, `err_underflow`) are 0 after that edge.
- R2: `coalesced` is 1 in the cycle after an edge where `line_assert` was 1 and `pend_cnt` was nonzero. Otherwise it is 0. The decision uses the count from before that edge, even if acknowledges arrive in the same cycle.
- R3: Suppose `deliver_vld` is 1 with `pend_cnt` equal to 0, and neither `trk_clear` nor `rs_step` is active. Then `pend_map` loads `deliver_map` and `pend_cnt` becomes its number of set bits, up to N_DEST. Acknowledges in that same cycle are ignored.
- R4: Suppose `deliver_vld` is 1 while `pend_cnt` is nonzero, and neither `trk_clear` nor `rs_step` is active. Then the delivery is refused and `err_deliver` pulses for one cycle. Acknowledges in that cycle are still applied.
- R5: Each `ack` bit whose `pend_map` bit is set clears that bit. `pend_cnt` drops by the number of such bits, and any number of bits may clear in one cycle.
- R6: An `ack` bit whose `pend_map` bit is already clear changes neither the bitmap nor the count.
- R7: `trk_clear` has the highest priority. It sets `pend_map` and `pend_cnt` to 0, whatever delivery, acknowledge or restore inputs arrive in the same cycle.
- R8: `rs_step` has priority over delivery and acknowledges. If `rs_match` is 1 and bit `rs_idx` differs from `rs_pend`, the bit takes the value of `rs_pend` and `pend_cnt` moves by one in the same direction. In every other case, the state is unchanged.
- R9: `pend_cnt` always equals the number of set bits in `pend_map`, and `err_underflow` never rises under any input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trk_clear | input | 1 | Clear tracking state (restore first phase) |
| deliver_vld | input | 1 | Delivery event |
| deliver_map | input | N_DEST | Destinations that accepted the delivery |
| ack | input | N_DEST | Per-destination acknowledge strobes |
| line_assert | input | 1 | New assertion on the tracked line |
| rs_step | input | 1 | One restore step |
| rs_idx | input | IW | Destination index for the restore step |
| rs_match | input | 1 | Destination is a target of the line |
| rs_pend | input | 1 | Destination still has the interrupt pending |
| pend_cnt | output | CW | Outstanding acknowledge count |
| pend_map | output | N_DEST | Outstanding acknowledge bitmap |
| coalesced | output | 1 | Previous assertion was coalesced |
| err_deliver | output | 1 | Delivery attempted with nonzero count |
| err_underflow | output | 1 | Count decrement below zero attempted |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes each pair.

- **Line assertion with the final acknowledges.** Both are driven on one edge. The bench expects `coalesced` to follow the pre-edge count while the count itself falls to zero. A following assertion must then be delivered and not coalesced.
- **Delivery with acknowledges.** This pair is driven on both the legal path and the refused path. On the legal path, the bitmap must equal the delivered map untouched by the acknowledges. On the refused path, the acknowledges must still take effect and `err_deliver` must pulse.

Each result is compared against a reference model that the bench builds from the requirements.

// File: rtl/ackt_pkg.sv
package ackt_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR   = 2'd0,
    OP_RESTORE = 2'd1,
    OP_DELIVER = 2'd2,
    OP_ACK     = 2'd3
  } ackt_op_e;
endpackage

// File: rtl/ackt_popcnt.sv
module ackt_popcnt #(
  parameter int W  = 16,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [OW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) begin
      count_o = count_o + OW'(bits_i[i]);
    end
  end
endmodule

// File: rtl/ackt_update.sv
module ackt_update
  import ackt_pkg::*;
#(
  parameter int N_DEST = 16,
  localparam int CW = $clog2(N_DEST + 1),
  localparam int IW = (N_DEST > 1) ? $clog2(N_DEST) : 1
) (
  input  logic [N_DEST-1:0] cur_map,
  input  logic [CW-1:0]     cur_cnt,
  input  logic              trk_clear,
  input  logic              rs_step,
  input  logic [IW-1:0]     rs_idx,
  input  logic              rs_match,
  input  logic              rs_pend,
  input  logic              deliver_vld,
  input  logic [N_DEST-1:0] deliver_map,
  input  logic [CW-1:0]     deliver_pop,
  input  logic [N_DEST-1:0] ack,
  input  logic [CW-1:0]     acked_pop,
  output logic [N_DEST-1:0] nxt_map,
  output logic [CW-1:0]     nxt_cnt,
  output logic              nxt_err_deliver,
  output logic              nxt_err_underflow
);
  ackt_op_e op;
  logic     idx_ok;
  logic     cur_bit;

  always_comb begin
    if (trk_clear)                          op = OP_CLEAR;
    else if (rs_step)                       op = OP_RESTORE;
    else if (deliver_vld && cur_cnt == '0)  op = OP_DELIVER;
    else                                    op = OP_ACK;
  end

  assign idx_ok  = (32'(rs_idx) < N_DEST);
  assign cur_bit = idx_ok ? cur_map[rs_idx] : 1'b0;

  always_comb begin
    nxt_map           = cur_map;
    nxt_cnt           = cur_cnt;
    nxt_err_deliver   = 1'b0;
    nxt_err_underflow = 1'b0;
    case (op)
      OP_CLEAR: begin
        nxt_map = '0;
        nxt_cnt = '0;
      end
      OP_RESTORE: begin
        if (rs_match && idx_ok && (cur_bit != rs_pend)) begin
          nxt_map[rs_idx] = rs_pend;
          if (rs_pend) begin
            nxt_cnt = cur_cnt + CW'(1);
          end else if (cur_cnt == '0) begin
            nxt_err_underflow = 1'b1;
          end else begin
            nxt_cnt = cur_cnt - CW'(1);
          end
        end
      end
      OP_DELIVER: begin
        nxt_map = deliver_map;
        nxt_cnt = deliver_pop;
      end
      default: begin
        nxt_err_deliver = deliver_vld;
        nxt_map         = cur_map & ~ack;
        if (acked_pop > cur_cnt) begin
          nxt_err_underflow = 1'b1;
          nxt_cnt           = '0;
        end else begin
          nxt_cnt = cur_cnt - acked_pop;
        end
      end
    endcase
  end
endmodule

// File: rtl/ackt_tracker.sv
module ackt_tracker #(
  parameter int N_DEST = 16,
  localparam int CW = $clog2(N_DEST + 1),
  localparam int IW = (N_DEST > 1) ? $clog2(N_DEST) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trk_clear,
  input  logic              deliver_vld,
  input  logic [N_DEST-1:0] deliver_map,
  input  logic [N_DEST-1:0] ack,
  input  logic              line_assert,
  input  logic              rs_step,
  input  logic [IW-1:0]     rs_idx,
  input  logic              rs_match,
  input  logic              rs_pend,
  output logic [CW-1:0]     pend_cnt,
  output logic [N_DEST-1:0] pend_map,
  output logic              coalesced,
  output logic              err_deliver,
  output logic              err_underflow
);
  logic [CW-1:0]     deliver_pop;
  logic [CW-1:0]     acked_pop;
  logic [N_DEST-1:0] nxt_map;
  logic [CW-1:0]     nxt_cnt;
  logic              nxt_err_deliver;
  logic              nxt_err_underflow;

  ackt_popcnt #(.W(N_DEST), .OW(CW)) u_pop_deliver (
    .bits_i  (deliver_map),
    .count_o (deliver_pop)
  );

  ackt_popcnt #(.W(N_DEST), .OW(CW)) u_pop_ack (
    .bits_i  (ack & pend_map),
    .count_o (acked_pop)
  );

  ackt_update #(.N_DEST(N_DEST)) u_update (
    .cur_map           (pend_map),
    .cur_cnt           (pend_cnt),
    .trk_clear         (trk_clear),
    .rs_step           (rs_step),
    .rs_idx            (rs_idx),
    .rs_match          (rs_match),
    .rs_pend           (rs_pend),
    .deliver_vld       (deliver_vld),
    .deliver_map       (deliver_map),
    .deliver_pop       (deliver_pop),
    .ack               (ack),
    .acked_pop         (acked_pop),
    .nxt_map           (nxt_map),
    .nxt_cnt           (nxt_cnt),
    .nxt_err_deliver   (nxt_err_deliver),
    .nxt_err_underflow (nxt_err_underflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_map      <= '0;
      pend_cnt      <= '0;
      coalesced     <= 1'b0;
      err_deliver   <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      pend_map      <= nxt_map;
      pend_cnt      <= nxt_cnt;
      coalesced     <= line_assert && (pend_cnt != '0);
      err_deliver   <= nxt_err_deliver;
      err_underflow <= nxt_err_underflow;
    end
  end
endmodule

// File: rtl/ackt_chk.sv
module ackt_chk #(
  parameter int N_DEST = 16,
  localparam int CW = $clog2(N_DEST + 1),
  localparam int IW = (N_DEST > 1) ? $clog2(N_DEST) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              trk_clear,
  input logic              deliver_vld,
  input logic [N_DEST-1:0] deliver_map,
  input logic [N_DEST-1:0] ack,
  input logic              line_assert,
  input logic              rs_step,
  input logic [IW-1:0]     rs_idx,
  input logic              rs_match,
  input logic              rs_pend,
  input logic [CW-1:0]     pend_cnt,
  input logic [N_DEST-1:0] pend_map,
  input logic              coalesced,
  input logic              err_deliver,
  input logic              err_underflow
);
  logic quiet;
  assign quiet = !trk_clear && !rs_step && !deliver_vld;

  // R9
  count_matches_map_chk: assert property (@(posedge clk) disable iff (rst)
    32'(pend_cnt) == $countones(pend_map));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    !err_underflow);

  // R2
  coalesce_chk: assert property (@(posedge clk) disable iff (rst)
    line_assert |=> (coalesced == ($past(pend_cnt) != '0)));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    trk_clear |=> (pend_cnt == '0 && pend_map == '0));

  // R3
  deliver_load_chk: assert property (@(posedge clk) disable iff (rst)
    (deliver_vld && pend_cnt == '0 && !trk_clear && !rs_step)
      |=> (pend_map == $past(deliver_map)));

  // R4
  deliver_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (deliver_vld && pend_cnt != '0 && !trk_clear && !rs_step)
      |=> (err_deliver && ((pend_map & ~$past(pend_map)) == '0)));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && (ack & pend_map) != '0)
      |=> ((pend_map & $past(ack)) == '0));

  // R6
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && (ack & pend_map) == '0) |=> $stable(pend_map));
endmodule

bind ackt_tracker ackt_chk #(.N_DEST(N_DEST)) u_chk (
  .clk(clk), .rst(rst), .trk_clear(trk_clear), .deliver_vld(deliver_vld),
  .deliver_map(deliver_map), .ack(ack), .line_assert(line_assert),
  .rs_step(rs_step), .rs_idx(rs_idx), .rs_match(rs_match), .rs_pend(rs_pend),
  .pend_cnt(pend_cnt), .pend_map(pend_map), .coalesced(coalesced),
  .err_deliver(err_deliver), .err_underflow(err_underflow)
);

// File: tb/test_ackt_tracker.sv
module test_ackt_tracker;
  localparam int N    = 16;
  localparam int CW   = $clog2(N + 1);
  localparam int IW   = $clog2(N);
  localparam int TCLK = 10;

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic [N-1:0]  map;
    logic          coal;
    logic          errd;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trk_clear = 0, deliver_vld = 0, line_assert = 0;
  logic rs_step = 0, rs_match = 0, rs_pend = 0;
  logic [IW-1:0] rs_idx = '0;
  logic [N-1:0]  deliver_map = '0, ack = '0;
  logic [CW-1:0] pend_cnt;
  logic [N-1:0]  pend_map;
  logic coalesced, err_deliver, err_underflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [N-1:0]  m_map = '0;
  logic [CW-1:0] m_cnt = '0;

  always #(TCLK/2) clk = ~clk;

  ackt_tracker #(.N_DEST(N)) i_ackt_tracker (
    .clk(clk), .rst(rst), .trk_clear(trk_clear), .deliver_vld(deliver_vld),
    .deliver_map(deliver_map), .ack(ack), .line_assert(line_assert),
    .rs_step(rs_step), .rs_idx(rs_idx), .rs_match(rs_match), .rs_pend(rs_pend),
    .pend_cnt(pend_cnt), .pend_map(pend_map), .coalesced(coalesced),
    .err_deliver(err_deliver), .err_underflow(err_underflow)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the reference result.
  task automatic step(input string tag, input logic clr, input logic dv,
                      input logic [N-1:0] dmap, input logic [N-1:0] a,
                      input logic la, input logic rs, input int ridx,
                      input logic rm, input logic rp);
    exp_t e;
    @(negedge clk);
    trk_clear = clr; deliver_vld = dv; deliver_map = dmap; ack = a;
    line_assert = la; rs_step = rs; rs_idx = IW'(ridx); rs_match = rm; rs_pend = rp;
    e.coal = la && (m_cnt != 0);
    e.errd = 1'b0;
    if (clr) begin
      m_map = '0;
    end else if (rs) begin
      if (rm) m_map[ridx] = rp;
    end else if (dv && m_cnt == 0) begin
      m_map = dmap;
    end else begin
      e.errd = dv;
      m_map  = m_map & ~a;
    end
    m_cnt = CW'($countones(m_map));
    e.cnt = m_cnt;
    e.map = m_map;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    step("idle", 0, 0, '0, '0, 0, 0, 0, 0, 0);
  endtask

  // Monitor: compares after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " cnt"},  64'(pend_cnt), 64'(e.cnt));
      check({t, " map"},  64'(pend_map), 64'(e.map));
      check({t, " coalesced"}, 64'(coalesced), 64'(e.coal));
      check({t, " err_deliver"}, 64'(err_deliver), 64'(e.errd));
      check({t, " R9 underflow"}, 64'(err_underflow), 64'd0);
      check({t, " R9 popcount"}, 64'(pend_cnt), 64'($countones(pend_map)));
    end
  end

  initial begin
    #(TCLK * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 cnt", 64'(pend_cnt), 0);
    check("R1 map", 64'(pend_map), 0);
    check("R1 flags", 64'({coalesced, err_deliver, err_underflow}), 0);
    rst = 1'b0;
    // bit i = destination i
    step("R2 no pending", 0, 0, '0, '0, 1, 0, 0, 0, 0);
    step("R3 deliver a5", 0, 1, 16'h00A5, '0, 0, 0, 0, 0, 0);
    step("R2 coalesce", 0, 0, '0, '0, 1, 0, 0, 0, 0);
    step("R5 ack d0", 0, 0, '0, 16'h0001, 0, 0, 0, 0, 0);
    step("R6 repeat ack d0", 0, 0, '0, 16'h0001, 0, 0, 0, 0, 0);
    step("R6 ack d3 clear", 0, 0, '0, 16'h0008, 0, 0, 0, 0, 0);
    step("R4 refused with ack d2", 0, 1, 16'hFFFF, 16'h0004, 0, 0, 0, 0, 0);
    step("R5 multi ack", 0, 0, '0, 16'h02A0, 0, 0, 0, 0, 0);
    step("R2 after drain", 0, 0, '0, '0, 1, 0, 0, 0, 0);
    step("R3 deliver with ack", 0, 1, 16'h8001, 16'h0001, 0, 0, 0, 0, 0);
    step("R2 assert with last acks", 0, 0, '0, 16'h8001, 1, 0, 0, 0, 0);
    step("R2 assert after drain", 0, 0, '0, '0, 1, 0, 0, 0, 0);
    step("R3 deliver all", 0, 1, 16'hFFFF, '0, 0, 0, 0, 0, 0);
    step("R7 clear overrides", 0 | 1, 1, 16'h00FF, 16'h0F0F, 0, 1, 2, 1, 1);
    step("R8 set d3", 0, 0, '0, '0, 0, 1, 3, 1, 1);
    step("R8 set d3 again", 0, 0, '0, '0, 0, 1, 3, 1, 1);
    step("R8 no match d7", 0, 0, '0, '0, 0, 1, 7, 0, 1);
    step("R8 set d15", 0, 0, '0, '0, 0, 1, 15, 1, 1);
    step("R8 clear d3", 0, 0, '0, '0, 0, 1, 3, 1, 0);
    step("R8 step blocks ack and deliver", 0, 1, 16'h0003, 16'h8000, 0, 1, 0, 1, 0);
    step("R5 ack d15", 0, 0, '0, 16'h8000, 0, 0, 0, 0, 0);
    idle();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule